// File: doc/BRIEF.md
# Level-1 Accept Window Readout

This block sits behind the hit inputs of a trigger front end. On every bunch crossing (one clock cycle) it stores the hit vector together with a 4-bit bunch-crossing stamp in a circular latency store that is `PIPE_DEPTH` entries deep. A level-1 accept that arrives `latency` cycles after a crossing selects that crossing. In the same cycle the block reads the crossing before it, the crossing itself and the crossing after it. Each of these becomes a tagged word, and the three words go into a derandomizing FIFO as one atomic group.

The FIFO drains through a valid/ready output stream. A word is transferred on any rising edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the word on `out_data` stays where it is. The sink may hold `out_ready` low for as long as it likes. If an accept finds fewer than three free FIFO slots, it is discarded whole and a sticky overflow flag is raised. A bunch-counter clear input restarts the crossing stamps. An event-counter clear input zeroes the count of stored accepts.

Top module: `l1_readout`

## Requirements
- R1: For an accept sampled on the edge of crossing t with latency L, three words are emitted in this order: crossing t-L-1, then t-L, then t-L+1. Crossing t is the hit vector sampled on that same edge.
- R2: Word layout: bits [CHANNELS-1:0] hold the hits. Bits [CHANNELS+3:CHANNELS] hold the crossing stamp. Bits [CHANNELS+5:CHANNELS+4] hold a position tag: 1 for the earlier crossing, 2 for the accepted one, 3 for the later one. Tag 0 never appears.
- R3: The crossing stamp is a 4-bit counter. It starts at 0 after reset, goes up by one per crossing and wraps from 15 to 0. A crossing sampled with `bc_reset` high keeps the old stamp, and the crossing after it is stamped 0.
- R4: `ev_count` counts stored accepts. When `ev_reset` is sampled high, it reads 0 after that edge. An accept on the same edge is not counted.
- R5: Any `latency` from 2 to PIPE_DEPTH-2 selects the correct window. Both ends of that range are supported.
- R6: `out_valid` is high exactly while the FIFO holds words. A word is held stable while `out_ready` is low and is removed on a valid and ready edge. Order is first in, first out.
- R7: An accept that finds the FIFO occupancy before that edge above FIFO_DEPTH-3 writes no word and is not counted. It sets `overflow`, which stays high until reset.
- R8: After reset, `out_valid`, `overflow` and `ev_count` are 0.
- R9: Accepts on consecutive crossings each produce a full three-word window, even where the windows share crossings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hits | input | CHANNELS | Hit vector of the current crossing |
| bc_reset | input | 1 | Restart crossing stamps at 0 |
| ev_reset | input | 1 | Zero the stored-accept counter |
| l1a | input | 1 | Level-1 accept for crossing minus latency |
| latency | input | log2(PIPE_DEPTH) | Accept latency in crossings, 2 to PIPE_DEPTH-2 |
| out_valid | output | 1 | FIFO holds a word |
| out_ready | input | 1 | Sink takes the word on this edge |
| out_data | output | CHANNELS+6 | Tagged, stamped hit word |
| ev_count | output | EV_W | Stored accepts since last clear |
| overflow | output | 1 | Sticky: an accept was dropped |

## Verification
The assertions assume that `latency` stays between 2 and PIPE_DEPTH-2 in every cycle where `l1a` is high. Outside that range the earliest or latest crossing of the window is not yet stored or has already been overwritten. The stimulus changes `latency` only between accepts and keeps it in range, including runs at exactly 2 and exactly 126. It first lets enough crossings pass after reset that every window refers to crossings already sampled. It never raises `ev_reset` on the same cycle as an accept, so the expected count never depends on that collision.

// File: rtl/l1r_pkg.sv
package l1r_pkg;
  localparam int BC_W  = 4;   // crossing stamp width
  localparam int TAG_W = 2;   // position tag width
  localparam int WIN   = 3;   // crossings per accept

  typedef enum logic [TAG_W-1:0] {
    TAG_NONE  = 2'd0,
    TAG_EARLY = 2'd1,
    TAG_ACC   = 2'd2,
    TAG_LATE  = 2'd3
  } xtag_e;
endpackage

// File: rtl/l1r_pipeline.sv
// Circular latency store: one write per crossing, WIN combinational taps
// centred on (write pointer - lat).
module l1r_pipeline #(
  parameter int WIDTH = 20,
  parameter int DEPTH = 128,
  parameter int TAPS  = 3,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [WIDTH-1:0]           din,
  input  logic [AW-1:0]              lat,
  output logic [TAPS-1:0][WIDTH-1:0] taps
);
  logic [WIDTH-1:0] store [DEPTH];
  logic [AW-1:0]    wptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      for (int i = 0; i < DEPTH; i++) store[i] <= '0;
    end else begin
      store[wptr] <= din;
      wptr        <= wptr + AW'(1);
    end
  end

  // tap k reads crossing (now - lat + k - 1); lat >= 2 keeps all taps in the past
  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    logic [AW-1:0] idx;
    assign idx     = wptr - lat + AW'(k) - AW'(1);
    assign taps[k] = store[idx];
  end
endmodule

// File: rtl/l1r_derand.sv
// Derandomizing FIFO: writes NW words in one cycle, drains one per handshake.
module l1r_derand #(
  parameter int WIDTH = 22,
  parameter int DEPTH = 128,
  parameter int NW    = 3,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [NW-1:0][WIDTH-1:0] wr_words,
  input  logic                     rd_ready,
  output logic                     rd_valid,
  output logic [WIDTH-1:0]         rd_word,
  output logic [AW:0]              count
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic             pop;

  assign rd_valid = (count != '0);
  assign rd_word  = mem[rptr];
  assign pop      = rd_valid && rd_ready;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int i = 0; i < NW; i++) mem[wptr + AW'(i)] <= wr_words[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (wr_en) wptr <= wptr + AW'(NW);
      if (pop)   rptr <= rptr + AW'(1);
      count <= count + (wr_en ? (AW+1)'(NW) : '0) - (pop ? (AW+1)'(1) : '0);
    end
  end

  // R7: the parent only writes a group when it fits
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> count <= (AW+1)'(DEPTH - NW));

  // R6: a stalled word stays on the output
  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_word));

  // R6: occupancy never exceeds the storage
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (AW+1)'(DEPTH));
endmodule

// File: rtl/l1r_ids.sv
// Crossing stamp and stored-accept counters.
module l1r_ids #(
  parameter int BC_W = 4,
  parameter int EV_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bc_clr,
  input  logic            ev_clr,
  input  logic            ev_inc,
  output logic [BC_W-1:0] bcnt,
  output logic [EV_W-1:0] evcnt
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bcnt  <= '0;
      evcnt <= '0;
    end else begin
      bcnt  <= bc_clr ? '0 : bcnt + BC_W'(1);
      if (ev_clr)      evcnt <= '0;
      else if (ev_inc) evcnt <= evcnt + EV_W'(1);
    end
  end

  // R3: a clear restarts the stamp at zero
  a_r3_bc_clear: assert property (@(posedge clk) disable iff (!rst_n)
    bc_clr |=> bcnt == '0);

  // R4: a clear zeroes the event count
  a_r4_ev_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ev_clr |=> evcnt == '0);
endmodule

// File: rtl/l1_readout.sv
module l1_readout import l1r_pkg::*; #(
  parameter int CHANNELS   = 16,
  parameter int PIPE_DEPTH = 128,
  parameter int FIFO_DEPTH = 128,
  parameter int EV_W       = 8,
  localparam int LAT_W     = $clog2(PIPE_DEPTH),
  localparam int WORD_W    = CHANNELS + BC_W + TAG_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CHANNELS-1:0] hits,
  input  logic                bc_reset,
  input  logic                ev_reset,
  input  logic                l1a,
  input  logic [LAT_W-1:0]    latency,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [WORD_W-1:0]   out_data,
  output logic [EV_W-1:0]     ev_count,
  output logic                overflow
);
  localparam int ENTRY_W = CHANNELS + BC_W;
  localparam int FAW     = $clog2(FIFO_DEPTH);
  localparam logic [FAW:0] ROOM_MAX = (FAW+1)'(FIFO_DEPTH - WIN);

  logic [BC_W-1:0]                bcnt;
  logic [WIN-1:0][ENTRY_W-1:0]    taps;
  logic [WIN-1:0][WORD_W-1:0]     group;
  logic [FAW:0]                   fifo_count;
  logic                           fits, accept;

  assign fits   = fifo_count <= ROOM_MAX;
  assign accept = l1a && fits;

  l1r_ids #(.BC_W(BC_W), .EV_W(EV_W)) u_ids (
    .clk(clk), .rst_n(rst_n), .bc_clr(bc_reset), .ev_clr(ev_reset),
    .ev_inc(accept), .bcnt(bcnt), .evcnt(ev_count)
  );

  l1r_pipeline #(.WIDTH(ENTRY_W), .DEPTH(PIPE_DEPTH), .TAPS(WIN)) u_pipe (
    .clk(clk), .rst_n(rst_n), .din({bcnt, hits}), .lat(latency), .taps(taps)
  );

  // tag 1/2/3 for earlier / accepted / later crossing
  for (genvar k = 0; k < WIN; k++) begin : g_word
    assign group[k] = {TAG_W'(k + 1), taps[k]};
  end

  l1r_derand #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH), .NW(WIN)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(accept), .wr_words(group),
    .rd_ready(out_ready), .rd_valid(out_valid), .rd_word(out_data),
    .count(fifo_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)             overflow <= 1'b0;
    else if (l1a && !fits)  overflow <= 1'b1;
  end

  // R5: accepts only with a latency whose window lies inside the store
  a_r5_latency_range: assert property (@(posedge clk) disable iff (!rst_n)
    l1a |-> (latency >= LAT_W'(2)) && (latency <= LAT_W'(PIPE_DEPTH - 2)));

  // R7: overflow is sticky
  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R7: a dropped accept raises the flag and is not counted
  a_r7_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
    l1a && !fits && !ev_reset |=> overflow && ev_count == $past(ev_count));

  // R2: every emitted word carries a position tag
  a_r2_tag_present: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_data[WORD_W-1 -: TAG_W] != TAG_NONE);
endmodule

// File: tb/l1_readout_test.sv
`timescale 1ns/1ps
module l1_readout_test;
  localparam int CH = 16, PD = 128, FD = 128, EW = 8, LW = 7;
  localparam int WW = CH + 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, bc_reset, ev_reset, l1a, out_valid, out_ready, overflow;
  logic [CH-1:0] hits;
  logic [LW-1:0] latency;
  logic [WW-1:0] out_data;
  logic [EW-1:0] ev_count;

  l1_readout #(.CHANNELS(CH), .PIPE_DEPTH(PD), .FIFO_DEPTH(FD), .EV_W(EW)) uut (
    .clk(clk), .rst_n(rst_n), .hits(hits), .bc_reset(bc_reset), .ev_reset(ev_reset),
    .l1a(l1a), .latency(latency), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .ev_count(ev_count), .overflow(overflow)
  );

  int checks = 0, errors = 0;
  logic [WW-1:0]  expq [$];
  logic [CH+3:0]  hist [256];
  logic [3:0]     bc_model = '0;
  int ev_model = 0, cyc = 0, pushed = 0, pops_done = 0, sink_mode = 0;
  bit ovf_model = 0, hs = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // driver: called at a negedge, sets inputs for the next edge, pushes expectations
  task automatic step(input bit acc, input bit bcr, input bit ecr);
    chk(ev_count == EW'(ev_model), "R4 event count", 64'(ev_count), 64'(ev_model));
    chk(overflow == ovf_model, "R7 overflow flag", 64'(overflow), 64'(ovf_model));
    hits     = CH'($urandom);
    l1a      = acc;
    bc_reset = bcr;
    ev_reset = ecr;
    hist[cyc % 256] = {bc_model, hits};
    if (acc) begin
      if (pushed - pops_done > FD - 3) ovf_model = 1;
      else begin
        for (int k = 0; k < 3; k++) begin
          int idx = cyc - int'(latency) - 1 + k;
          expq.push_back({2'(k + 1), hist[idx % 256]});
        end
        pushed += 3;
        if (!ecr) ev_model++;
      end
    end
    if (ecr) ev_model = 0;
    bc_model = bcr ? 4'd0 : bc_model + 4'd1;
    cyc++;
    @(negedge clk);
  endtask

  // monitor: after each edge, compare the head word and choose ready
  initial begin
    out_ready = 1'b0;
    @(posedge rst_n);
    forever begin
      @(posedge clk);
      if (hs) pops_done++;
      #4;
      chk(out_valid == (expq.size() != 0), "R6 valid vs occupancy",
          64'(out_valid), 64'(expq.size() != 0));
      if (out_valid && expq.size() != 0)
        chk(out_data == expq[0], "R1 R2 window word", 64'(out_data), 64'(expq[0]));
      case (sink_mode)
        0:       out_ready = 1'b1;
        1:       out_ready = 1'($urandom % 2);
        default: out_ready = 1'b0;
      endcase
      hs = out_valid && out_ready;
      if (hs && expq.size() != 0) void'(expq.pop_front());
    end
  end

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 0; hits = '0; bc_reset = 0; ev_reset = 0; l1a = 0; latency = 7'd5;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(out_valid == 0, "R8 reset valid", 64'(out_valid), 0);
    chk(overflow == 0, "R8 reset overflow", 64'(overflow), 0);
    chk(ev_count == 0, "R8 reset event count", 64'(ev_count), 0);
    rst_n = 1;

    // R1: sparse accepts, latency 5
    for (int i = 0; i < 20; i++) step(0, 0, 0);
    for (int i = 0; i < 42; i++) step(i % 7 == 3, 0, 0);

    // R5 lower bound and R9 back-to-back accepts
    latency = 7'd2;
    for (int i = 0; i < 5; i++) step(0, 0, 0);
    for (int i = 0; i < 3; i++) step(1, 0, 0);
    for (int i = 0; i < 10; i++) step(0, 0, 0);

    // R5 upper bound (PD-2)
    latency = 7'd126;
    for (int i = 0; i < 60; i++) step(0, 0, 0);
    step(1, 0, 0);
    step(0, 0, 0);
    step(1, 0, 0);
    for (int i = 0; i < 5; i++) step(0, 0, 0);

    // R3 stamp restart: window straddles the clear
    latency = 7'd4;
    step(0, 1, 0);
    for (int i = 0; i < 2; i++) step(0, 0, 0);
    step(1, 0, 0);
    // R3 stamp wrap past 15
    for (int i = 0; i < 14; i++) step(0, 0, 0);
    step(1, 0, 0);
    step(1, 0, 0);
    // R4 clear
    step(0, 0, 1);
    for (int i = 0; i < 4; i++) step(0, 0, 0);
    step(1, 0, 0);

    // R6 random back-pressure
    sink_mode = 1;
    latency = 7'd10;
    for (int i = 0; i < 200; i++) step(($urandom % 4) == 0, 0, 0);
    sink_mode = 0;
    for (int i = 0; i < 300 && expq.size() != 0; i++) step(0, 0, 0);

    // R7 fill a stalled FIFO until accepts are dropped
    sink_mode = 2;
    latency = 7'd8;
    for (int i = 0; i < 50; i++) step(1, 0, 0);
    for (int i = 0; i < 3; i++) step(0, 0, 0);
    chk(overflow == 1, "R7 overflow raised", 64'(overflow), 1);
    sink_mode = 0;
    for (int i = 0; i < 200; i++) step(0, 0, 0);
    chk(overflow == 1, "R7 overflow sticky after drain", 64'(overflow), 1);
    chk(expq.size() == 0, "R6 all expected words drained", 64'(expq.size()), 0);
    chk(out_valid == 0, "R6 empty after drain", 64'(out_valid), 0);
    finish_run();
  end
endmodule